// File: doc/BRIEF.md
# Signed Booth Multiplier with Carry-Save Reduction Tree

This block multiplies two two's-complement operands of independently chosen widths and returns the full-width signed product, with no rounding or truncation. The multiplier operand is recoded in radix 4, so roughly half as many partial-product rows are formed as there are operand bits. Each row is laid at full product width, shifted to its column and zero-padded. Two extra rows join them: one gathers the +1 terms of negated selections, and one constant row settles sign extension for every row at once. A tree of carry-save compressors reduces the whole set to two rows. It uses four-input compressors where it can and three-input compressors for an odd remainder. A single carry-propagate add at the end produces the result.

The arithmetic is a single combinational path. One output register sits at the stream edge with a valid/ready pair on each side. An operand pair is taken on a clock edge when `in_valid` and `in_ready` are both high, and its product is offered on the next edge. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold, and `in_ready` drops, so back-pressure reaches the producer in the same cycle. When the consumer is taking the held result, `in_ready` is high and a new pair can enter on the same edge.

Top module: `booth_csa_mult`

## Requirements
- R1: With the default 10x10 widths, every accepted pair yields `product` equal to the signed product of `a` and `b`, as an `NA+NB`-bit two's-complement value.
- R2: The product stays exact for other width pairs, including equal small widths (4x4, all 256 pairs) and an asymmetric pair whose multiplier width is odd (12x7).
- R3: When `in_valid && in_ready` is high at a clock edge, `out_valid` is high after that edge and `product` holds the result for that pair.
- R4: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next edge `out_valid` stays high with `product` unchanged.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: When a result is taken (`out_valid && out_ready`) and no new pair is accepted on that edge, `out_valid` is low after the edge.
- R7: While `rst_n` is low, `out_valid` is low. After reset releases, `in_ready` is high.
- R8: Corner operands give exact products: zero, -1, +1, the most negative value and the most positive value, in every combination on both inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair on `a`/`b` is valid |
| in_ready | output | 1 | Block can accept an operand pair this cycle |
| a | input | NA | Multiplicand, two's complement |
| b | input | NB | Multiplier (Booth-recoded), two's complement |
| out_valid | output | 1 | `product` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| product | output | NA+NB | Signed product |

## Verification
The bench builds the block three times. The 4x4 build is checked exhaustively, which covers every Booth digit pattern and every sign combination of a narrow tree. The 10x10 build gets random pairs and the full cross of corner operands, and its seven-row set drives both compressor kinds in the first tree level. The 12x7 build has an odd multiplier width, so the top Booth triplet is sign-extended, and its unequal operands stress the constant correction row and the top-column carry drops. Every build runs under a randomly stalling consumer, so the hold, drain and same-edge refill paths of the output register are exercised.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  // One radix-4 Booth digit: magnitude select and sign.
  typedef struct packed {
    logic neg;   // negate the selected multiple
    logic one;   // select 1 x multiplicand
    logic two;   // select 2 x multiplicand
  } bcm_digit_t;

  // Recode a triplet {b[2i+1], b[2i], b[2i-1]}.
  function automatic bcm_digit_t booth_digit(input logic [2:0] t);
    bcm_digit_t d;
    d.neg = t[2];
    d.one = t[1] ^ t[0];
    d.two = (t == 3'b011) || (t == 3'b100);
    return d;
  endfunction

  // Number of Booth partial-product rows for a multiplier width.
  function automatic int booth_rows(input int nb);
    return (nb + 1) / 2;
  endfunction

  // Rows left after one reduction level of n rows.
  function automatic int next_rows(input int n);
    int g;
    int r;
    g = n / 4;
    r = n % 4;
    return 2 * g + ((r == 3) ? 2 : r);
  endfunction

endpackage

// File: rtl/bcm_comp42.sv
// Row-wide 4:2 compressor: two full-adder layers per column, with a lateral
// carry from the first layer into the next column. Top-column carries drop.
module bcm_comp42 #(
  parameter int W = 20
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  logic [W-1:0] s1;
  logic [W-2:0] c1;
  logic [W-1:0] cin;
  logic [W-2:0] cy;

  always_comb begin
    s1  = x0 ^ x1 ^ x2;
    c1  = (x0[W-2:0] & x1[W-2:0]) | (x0[W-2:0] & x2[W-2:0]) | (x1[W-2:0] & x2[W-2:0]);
    cin = {c1, 1'b0};
    sum_o = s1 ^ x3 ^ cin;
    cy  = (s1[W-2:0] & x3[W-2:0]) | (s1[W-2:0] & cin[W-2:0]) | (x3[W-2:0] & cin[W-2:0]);
    car_o = {cy, 1'b0};
  end
endmodule

// File: rtl/bcm_comp32.sv
// Row-wide 3:2 compressor (one full adder per column).
module bcm_comp32 #(
  parameter int W = 20
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  logic [W-2:0] cy;

  always_comb begin
    sum_o = x0 ^ x1 ^ x2;
    cy    = (x0[W-2:0] & x1[W-2:0]) | (x0[W-2:0] & x2[W-2:0]) | (x1[W-2:0] & x2[W-2:0]);
    car_o = {cy, 1'b0};
  end
endmodule

// File: rtl/bcm_booth_rows.sv
// Builds the full-width row set: one row per Booth digit, one row of +1
// terms for negated digits, and one constant sign-correction row.
module bcm_booth_rows
  import bcm_pkg::*;
#(
  parameter int NA = 10,
  parameter int NB = 10,
  localparam int PW    = NA + NB,
  localparam int NPP   = booth_rows(NB),
  localparam int NROWS = NPP + 2
) (
  input  logic [NA-1:0]       a,
  input  logic [NB-1:0]       b,
  output logic [NROWS*PW-1:0] rows_o
);
  localparam int BX = 2 * NPP + 1;

  // Each row's top bit is stored inverted; this constant removes the
  // resulting 2^(2i+NA) offsets in one row.
  function automatic logic [PW-1:0] corr_const();
    logic [PW-1:0] k;
    k = '0;
    for (int i = 0; i < NPP; i++) k = k - (PW'(1) << (2 * i + NA));
    return k;
  endfunction

  localparam logic [PW-1:0] KROW = corr_const();

  logic signed [BX-2:0] b_sx;
  logic [BX-1:0]        b_ext;
  logic [NA:0]          a_x1;
  logic [NA:0]          a_x2;
  logic [NPP-1:0]       negs;

  assign b_sx  = (BX-1)'($signed(b));
  assign b_ext = {b_sx, 1'b0};
  assign a_x1  = {a[NA-1], a};
  assign a_x2  = {a, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_row
    bcm_digit_t  dig;
    logic [NA:0] mag;
    logic [NA:0] pp;

    always_comb begin
      dig = booth_digit(b_ext[2*i +: 3]);
      mag = dig.one ? a_x1 : (dig.two ? a_x2 : '0);
      pp  = mag ^ {(NA+1){dig.neg}};
    end

    assign negs[i] = dig.neg;
    assign rows_o[i*PW +: PW] = PW'({~pp[NA], pp[NA-1:0]}) << (2 * i);
  end

  // +1 terms of negated selections, each at its row's least significant bit.
  always_comb begin
    rows_o[NPP*PW +: PW] = '0;
    for (int i = 0; i < NPP; i++) rows_o[NPP*PW + 2*i] = negs[i];
  end

  assign rows_o[(NPP+1)*PW +: PW] = KROW;
endmodule

// File: rtl/bcm_csa_tree.sv
// Recursive carry-save tree: one level of 4:2 groups (3:2 for a remainder
// of three, pass-through for one or two), then itself on the result.
module bcm_csa_tree
  import bcm_pkg::*;
#(
  parameter int W = 20,
  parameter int N = 7
) (
  input  logic [N*W-1:0] rows_i,
  output logic [2*W-1:0] pair_o
);
  if (N <= 2) begin : g_leaf
    assign pair_o = rows_i;
  end else begin : g_level
    localparam int G  = N / 4;
    localparam int R  = N % 4;
    localparam int NO = next_rows(N);

    logic [NO*W-1:0] nxt;

    for (genvar g = 0; g < G; g++) begin : g_c42
      bcm_comp42 #(.W(W)) u_c42 (
        .x0    (rows_i[(4*g)*W   +: W]),
        .x1    (rows_i[(4*g+1)*W +: W]),
        .x2    (rows_i[(4*g+2)*W +: W]),
        .x3    (rows_i[(4*g+3)*W +: W]),
        .sum_o (nxt[(2*g)*W      +: W]),
        .car_o (nxt[(2*g+1)*W    +: W])
      );
    end

    if (R == 3) begin : g_c32
      bcm_comp32 #(.W(W)) u_c32 (
        .x0    (rows_i[(4*G)*W   +: W]),
        .x1    (rows_i[(4*G+1)*W +: W]),
        .x2    (rows_i[(4*G+2)*W +: W]),
        .sum_o (nxt[(2*G)*W      +: W]),
        .car_o (nxt[(2*G+1)*W    +: W])
      );
    end else begin : g_pass
      for (genvar r = 0; r < R; r++) begin : g_p
        assign nxt[(2*G+r)*W +: W] = rows_i[(4*G+r)*W +: W];
      end
    end

    bcm_csa_tree #(.W(W), .N(NO)) u_next (
      .rows_i (nxt),
      .pair_o (pair_o)
    );
  end
endmodule

// File: rtl/booth_csa_mult.sv
module booth_csa_mult
  import bcm_pkg::*;
#(
  parameter int NA = 10,
  parameter int NB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NA-1:0]    a,
  input  logic [NB-1:0]    b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NA+NB-1:0] product
);
  localparam int PW    = NA + NB;
  localparam int NROWS = booth_rows(NB) + 2;

  logic [NROWS*PW-1:0] rows;
  logic [2*PW-1:0]     pair;
  logic [PW-1:0]       prod_d;
  logic                take;

  bcm_booth_rows #(.NA(NA), .NB(NB)) u_rows (
    .a      (a),
    .b      (b),
    .rows_o (rows)
  );

  bcm_csa_tree #(.W(PW), .N(NROWS)) u_tree (
    .rows_i (rows),
    .pair_o (pair)
  );

  // The only carry-propagate add in the datapath.
  assign prod_d = pair[PW-1:0] + pair[2*PW-1:PW];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      product   <= prod_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int NA = 10,
  parameter int NB = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NA-1:0]    a,
  input logic [NB-1:0]    b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NA+NB-1:0] product
);
  logic signed [NA+NB-1:0] model_p;
  assign model_p = $signed(a) * $signed(b);

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && product == $past(model_p)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_reset_r7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind booth_csa_mult bcm_checker #(.NA(NA), .NB(NB)) u_bcm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .product   (product)
);

// File: tb/bcm_lane.sv
// One DUT build with its driver, random-stall consumer and scoreboard.
// MODE 0: exhaustive pairs; MODE 1: corner cross plus NRAND random pairs.
module bcm_lane #(
  parameter int NA    = 10,
  parameter int NB    = 10,
  parameter int MODE  = 1,
  parameter int NRAND = 1000
) (
  input logic clk,
  input logic rst_n
);
  localparam int PW = NA + NB;

  logic          in_valid  = 1'b0;
  logic          out_ready = 1'b0;
  logic [NA-1:0] a = '0;
  logic [NB-1:0] b = '0;
  logic          in_ready;
  logic          out_valid;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [PW:0] sb_q[$];   // {corner flag, expected product}

  booth_csa_mult #(.NA(NA), .NB(NB)) u_booth_csa_mult (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .product   (product)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane %0dx%0d %s: actual %0h expected %0h",
               tag, NA, NB, what, act, exp);
    end
  endtask

  task automatic send(input logic [NA-1:0] av, input logic [NB-1:0] bv,
                      input bit corner);
    logic signed [PW-1:0] e;
    e = $signed(av) * $signed(bv);
    @(negedge clk);
    in_valid = 1'b1;
    a = av;
    b = bv;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb_q.push_back({corner, e});
    @(posedge clk);
  endtask

  function automatic logic [NA-1:0] corner_a(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return NA'(1);
      3: return {1'b1, {(NA-1){1'b0}}};
      default: return {1'b0, {(NA-1){1'b1}}};
    endcase
  endfunction

  function automatic logic [NB-1:0] corner_b(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return NB'(1);
      3: return {1'b1, {(NB-1){1'b0}}};
      default: return {1'b0, {(NB-1){1'b1}}};
    endcase
  endfunction

  // Driver
  initial begin
    @(posedge rst_n);
    repeat (2) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R7", "out_valid after reset", PW'(out_valid), '0);
    chk(in_ready == 1'b1, "R7", "in_ready after reset", PW'(in_ready), PW'(1));
    if (MODE == 0) begin
      for (int i = 0; i < (1 << NA); i++)
        for (int j = 0; j < (1 << NB); j++)
          send(NA'(i), NB'(j), 1'b0);
    end else begin
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          send(corner_a(i), corner_b(j), 1'b1);
      for (int n = 0; n < NRAND; n++)
        send(NA'($urandom), NB'($urandom), 1'b0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  // Consumer: mostly ready, with periodic stall bursts.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if ((cyc % 50) < 6) out_ready = 1'b0;
      else out_ready = (($urandom % 4) != 0);
    end
  end

  // Monitor / scoreboard
  initial begin
    bit            exp_load  = 1'b0;
    bit            exp_drain = 1'b0;
    bit            was_stall = 1'b0;
    logic [PW-1:0] held      = '0;
    logic [PW:0]   item;
    string         tag;
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) continue;
      if (exp_load)
        chk(out_valid == 1'b1, "R3", "out_valid after accept", PW'(out_valid), PW'(1));
      if (exp_drain)
        chk(out_valid == 1'b0, "R6", "out_valid after drain", PW'(out_valid), '0);
      if (was_stall)
        chk(out_valid && product == held, "R4", "held result", product, held);
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R4", "in_ready during stall", PW'(in_ready), '0);
      chk(in_ready == (!out_valid || out_ready), "R5", "in_ready",
          PW'(in_ready), PW'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", product, '0);
        end else begin
          item = sb_q.pop_front();
          if (NA == 10 && NB == 10) tag = item[PW] ? "R8" : "R1";
          else tag = "R2";
          chk(product == item[PW-1:0], tag, "product", product, item[PW-1:0]);
        end
      end
      exp_load  = in_valid && in_ready;
      exp_drain = out_valid && out_ready && !(in_valid && in_ready);
      was_stall = out_valid && !out_ready;
      held      = product;
    end
  end
endmodule

// File: tb/booth_csa_mult_bench.sv
module booth_csa_mult_bench;
  logic clk   = 1'b0;
  logic rst_n = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bcm_lane #(.NA(4),  .NB(4),  .MODE(0), .NRAND(0))    u_lane4  (.clk(clk), .rst_n(rst_n));
  bcm_lane #(.NA(10), .NB(10), .MODE(1), .NRAND(2000)) u_lane10 (.clk(clk), .rst_n(rst_n));
  bcm_lane #(.NA(12), .NB(7),  .MODE(1), .NRAND(1500)) u_lane12 (.clk(clk), .rst_n(rst_n));

  initial begin
    int cycles = 0;
    int checks;
    int errors;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(u_lane4.done && u_lane10.done && u_lane12.done) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks = u_lane4.checks + u_lane10.checks + u_lane12.checks;
    errors = u_lane4.errors + u_lane10.errors + u_lane12.errors;
    if (!(u_lane4.done && u_lane10.done && u_lane12.done)) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule